// File: doc/BRIEF.md
# Configurable I/O Storage Cell

This block is one storage bit of the kind placed next to an I/O pad, where it registers data on the way in or out of the chip, or an output-enable. Elaboration parameters fix its character. It can be an edge-triggered flip-flop or a level-sensitive latch. Its force input can act on the clock or at once, and it can drive the bit to 1 or to 0. A global initialisation input loads a chosen start-up value.

The cell has a data input, a clock that also serves as the latch gate, and a clock enable. It has a force input (`sr`), an opposite-force input (`rev`) and a global initialisation input (`gsr`). Its single output is the stored bit. When no start-up value is given, the start-up value is the same as the force value. This way a cell set up to force 1 also starts at 1.

Top module: `io_store_cell`

## Requirements
- R1: While `gsr` is 1, `q` equals the start-up value at once, whatever the clock and the other inputs are doing.
- R2: Parameter `INIT_SEL` chooses the start-up value: 0 or 1 gives that value, and -1 (the default) gives 1 when `SR_FORCES_ONE`=1 and 0 when `SR_FORCES_ONE`=0.
- R3: With `LATCH_MODE`=0 and no control input asserted, a rising clock edge stores `d` when `ce`=1, and `q` holds its value when `ce`=0.
- R4: With `LATCH_MODE`=1 and no control input asserted, `q` follows `d` while the gate `clk` is 1 and `ce` is 1, and it holds while `clk` is 0 or `ce` is 0.
- R5: An asserted `sr` drives `q` to the force value, which is 1 when `SR_FORCES_ONE`=1 and 0 otherwise. `ce` does not matter.
- R6: An asserted `rev` with `sr` low drives `q` to the inverse of the force value. `ce` does not matter.
- R7: With `SR_ASYNC`=0, `sr` and `rev` have no effect while the clock is low. They take effect at the rising edge (flip-flop) or while the gate is high (latch).
- R8: With `SR_ASYNC`=1, `sr` and `rev` change `q` as soon as they are asserted, even while the clock is low.
- R9: The inputs rank as follows: `gsr` first, then `sr`, then `rev`, then data. When `sr` and `rev` are both asserted, `q` takes the force value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock in flip-flop mode; gate in latch mode |
| ce | input | 1 | Clock enable for data capture |
| d | input | 1 | Data input |
| sr | input | 1 | Force input (to 1 or 0 per `SR_FORCES_ONE`) |
| rev | input | 1 | Opposite-force input |
| gsr | input | 1 | Global initialisation, asynchronous, highest priority |
| q | output | 1 | Stored bit |

## Verification
The assertions check on every clock cycle that a held `gsr` gives the start-up value. They check that `sr` gives the force value, that a lone `rev` gives its inverse, and that capture or hold follows `ce`. In the asynchronous variants they also check that the force is already visible before the next edge. Other behaviour shows only when the bench looks at `q` in both clock phases across four parameter sets. That covers the delayed action of forces in the synchronous variants during the low phase, a latch holding through its low phase, and the explicit start-up value overriding the coupled default.

// File: rtl/io_store_cell.sv
`timescale 1ns/1ps
module io_store_cell #(
  parameter bit LATCH_MODE    = 1'b0,
  parameter bit SR_ASYNC      = 1'b1,
  parameter bit SR_FORCES_ONE = 1'b0,
  parameter int INIT_SEL      = -1
) (
  input  logic clk,
  input  logic ce,
  input  logic d,
  input  logic sr,
  input  logic rev,
  input  logic gsr,
  output logic q
);
  localparam bit SR_VAL   = SR_FORCES_ONE;
  localparam bit REV_VAL  = !SR_FORCES_ONE;
  localparam bit INIT_VAL = (INIT_SEL < 0) ? SR_FORCES_ONE : (INIT_SEL != 0);

  logic st;
  logic force_any;
  logic force_val;

  assign force_any = sr | rev;
  assign force_val = sr ? SR_VAL : REV_VAL;
  assign q = st;

  generate
    if (!LATCH_MODE && SR_ASYNC) begin : g_ff_async
      always_ff @(posedge clk or posedge gsr or posedge sr or posedge rev) begin
        if (gsr)      st <= INIT_VAL;
        else if (sr)  st <= SR_VAL;
        else if (rev) st <= REV_VAL;
        else if (ce)  st <= d;
      end
    end else if (!LATCH_MODE) begin : g_ff_sync
      always_ff @(posedge clk or posedge gsr) begin
        if (gsr)            st <= INIT_VAL;
        else if (force_any) st <= force_val;
        else if (ce)        st <= d;
      end
    end else begin : g_latch
      logic ctl_on;
      logic open_g;
      assign ctl_on = SR_ASYNC ? force_any : (force_any & clk);
      assign open_g = clk & ce;
      always_latch begin
        if (gsr)         st <= INIT_VAL;
        else if (ctl_on) st <= force_val;
        else if (open_g) st <= d;
      end
    end
  endgenerate
endmodule

// File: rtl/io_store_cell_chk.sv
`timescale 1ns/1ps
module io_store_cell_chk #(
  parameter bit LATCH_MODE    = 1'b0,
  parameter bit SR_ASYNC      = 1'b1,
  parameter bit SR_FORCES_ONE = 1'b0,
  parameter int INIT_SEL      = -1
) (
  input logic clk,
  input logic ce,
  input logic d,
  input logic sr,
  input logic rev,
  input logic gsr,
  input logic q
);
  localparam bit FV = SR_FORCES_ONE;
  localparam bit IV = (INIT_SEL < 0) ? SR_FORCES_ONE : (INIT_SEL != 0);

  logic d_s, ce_s, sr_s, rev_s, g_s, q_s;
  always_ff @(posedge clk) begin
    d_s   <= d;
    ce_s  <= ce;
    sr_s  <= sr;
    rev_s <= rev;
    g_s   <= gsr;
    q_s   <= q;
  end

  // R1 / R2
  a_r1_gsr_loads_init: assert property (@(negedge clk) g_s |-> q == IV);

  // R5 / R9
  a_r5_sr_forces: assert property (@(negedge clk) disable iff (gsr)
    (sr_s && !g_s) |-> q == FV);

  // R6
  a_r6_rev_inverts: assert property (@(negedge clk) disable iff (gsr)
    (!sr_s && rev_s && !g_s) |-> q == !FV);

  // R3 / R4 capture
  a_r3_capture: assert property (@(negedge clk) disable iff (gsr)
    (ce_s && !sr_s && !rev_s && !g_s) |-> q == d_s);

  // R3 / R4 hold
  a_r4_hold: assert property (@(negedge clk) disable iff (gsr)
    (!ce_s && !sr_s && !rev_s && !g_s) |-> q == q_s);

  generate
    if (SR_ASYNC) begin : g_async_chk
      // R8
      a_r8_async_force: assert property (@(posedge clk) disable iff (gsr)
        sr |-> q == FV);
    end
  endgenerate
endmodule

bind io_store_cell io_store_cell_chk #(
  .LATCH_MODE(LATCH_MODE), .SR_ASYNC(SR_ASYNC),
  .SR_FORCES_ONE(SR_FORCES_ONE), .INIT_SEL(INIT_SEL)
) chk_i (
  .clk(clk), .ce(ce), .d(d), .sr(sr), .rev(rev), .gsr(gsr), .q(q)
);

// File: tb/io_store_cell_tb_top.sv
`timescale 1ns/1ps
module io_store_cell_tb_top;
  logic clk = 1'b0;
  logic ce = 1'b0, d = 1'b0, sr = 1'b0, rev = 1'b0, gsr = 1'b1;
  logic [3:0] qv;
  logic exp_q [4];
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  // cfg0: ff async force1 init default; cfg1: ff sync force0 init 1
  // cfg2: latch async force0 init default; cfg3: latch sync force1 init 0
  function automatic bit is_latch(int k); return k >= 2; endfunction
  function automatic bit is_async(int k); return (k == 0) || (k == 2); endfunction
  function automatic bit fval(int k); return (k == 0) || (k == 3); endfunction
  function automatic int isel(int k); return (k == 1) ? 1 : (k == 3) ? 0 : -1; endfunction
  function automatic bit init_of(int k);
    return (isel(k) < 0) ? fval(k) : (isel(k) != 0);
  endfunction

  for (genvar k = 0; k < 4; k++) begin : cfg
    io_store_cell #(
      .LATCH_MODE((k >= 2) ? 1'b1 : 1'b0),
      .SR_ASYNC(((k == 0) || (k == 2)) ? 1'b1 : 1'b0),
      .SR_FORCES_ONE(((k == 0) || (k == 3)) ? 1'b1 : 1'b0),
      .INIT_SEL((k == 1) ? 1 : (k == 3) ? 0 : -1)
    ) dut_i (
      .clk(clk), .ce(ce), .d(d), .sr(sr), .rev(rev), .gsr(gsr), .q(qv[k])
    );
  end

  function automatic bit low_model(int k, bit cur);
    if (gsr) return init_of(k);
    if (is_async(k) && sr) return fval(k);
    if (is_async(k) && rev) return !fval(k);
    return cur;
  endfunction

  function automatic bit high_model(int k, bit cur);
    if (gsr) return init_of(k);
    if (sr) return fval(k);
    if (rev) return !fval(k);
    if (ce) return d;
    return cur;
  endfunction

  function automatic string low_tag(int k);
    if (gsr) return "R1";
    if (sr || rev) return is_async(k) ? "R8" : "R7";
    return is_latch(k) ? "R4" : "R3";
  endfunction

  function automatic string high_tag(int k);
    if (gsr) return "R1";
    if (sr && rev) return "R9";
    if (sr) return "R5";
    if (rev) return "R6";
    return is_latch(k) ? "R4" : "R3";
  endfunction

  task automatic check_all(input bit high, input bit first);
    for (int k = 0; k < 4; k++) begin
      string tg;
      tg = first ? "R2" : (high ? high_tag(k) : low_tag(k));
      total++;
      if (qv[k] !== exp_q[k]) begin
        bad++;
        $display("FAIL %s cfg%0d t=%0t q=%b expected=%b", tg, k, $time, qv[k], exp_q[k]);
      end
    end
  endtask

  task automatic step(input bit g, input bit s, input bit r, input bit c, input bit dv,
                      input bit first);
    @(negedge clk);
    gsr = g; sr = s; rev = r; ce = c; d = dv;
    for (int k = 0; k < 4; k++) exp_q[k] = low_model(k, exp_q[k]);
    #1 check_all(1'b0, first);
    @(posedge clk);
    for (int k = 0; k < 4; k++) exp_q[k] = high_model(k, exp_q[k]);
    #1 check_all(1'b1, first);
  endtask

  initial begin
    bit prev_ctl;
    void'($urandom(32'd2718));
    for (int k = 0; k < 4; k++) exp_q[k] = init_of(k);
    // R2: start-up value, coupled default and explicit override
    step(1, 0, 0, 1, 1, 1'b1);
    // R3 / R4 capture and hold
    step(0, 0, 0, 1, 1, 1'b0);
    step(0, 0, 0, 1, 0, 1'b0);
    step(0, 0, 0, 0, 1, 1'b0);
    // R9: sr and rev together
    step(0, 1, 1, 1, 0, 1'b0);
    step(0, 0, 0, 0, 0, 1'b0);
    // R6
    step(0, 0, 1, 1, 1, 1'b0);
    step(0, 0, 0, 0, 1, 1'b0);
    // R5 with ce low
    step(0, 1, 0, 0, 0, 1'b0);
    step(0, 0, 0, 0, 0, 1'b0);
    // R1 over sr
    step(1, 1, 0, 1, 1, 1'b0);
    step(0, 0, 0, 1, 1, 1'b0);
    prev_ctl = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      bit g, s, r, c, dv;
      g = ($urandom % 32) == 0;
      s = ($urandom % 8) == 0;
      r = ($urandom % 8) == 0;
      c = ($urandom % 4) != 0;
      dv = $urandom % 2;
      if (prev_ctl) begin g = 0; s = 0; r = 0; end
      prev_ctl = g | s | r;
      step(g, s, r, c, dv, 1'b0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog expired t=%0t q=%b expected=done", $time, qv);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule